// File: doc/BRIEF.md
# Four-Instruction 8-bit Processor Core

This block is a single-cycle processor core with four operations: register add, memory load, memory store and relative jump. On every rising clock edge it executes one 8-bit instruction. The instruction comes in on an input port, and the core supplies that instruction's address on its program-counter output. The instruction store sits outside the core. The core holds four 8-bit general registers and a 32-word data store of 8-bit words. The data store powers up with a fixed pattern.

An instruction is cut into four 2-bit fields. The opcode sits in bits [7:6]. Field A in bits [5:4] is always a source register. Field B in bits [3:2] is a source for add, and for memory operations it is the data register. Field C in bits [1:0] is either the add destination or a signed offset. Decoded strobes show the current opcode combinationally. After each edge, a small report group shows which register was last written and the value it received, plus a flag for cycles that wrote no register.

Top module: `cpu4_core`

## Requirements
- R1: While the active-high asynchronous reset `rst` is high, `pc_out` is 0, `wb_none` is 1, and `wb_reg` and `wb_val` are 0. All four registers read 0 after reset.
- R2: The instruction bits map as follows: opcode = [7:6], field A = [5:4], field B = [3:2], field C = [1:0]. Opcodes are 00 add, 01 load, 10 store and 11 jump.
- R3: The outputs `mem_wr`, `mem_rd`, `reg_wr` and `op_out` follow the present instruction combinationally. `mem_wr` is 1 only for opcode 10. `mem_rd` is 1 only for opcode 01. `reg_wr` is the inverse of opcode bit 7. `op_out` equals bits [7:6].
- R4: Add writes reg[A] + reg[B], modulo 256, into reg[C].
- R5: Load writes dmem[(reg[A] + sext(C)) mod 32] into reg[B]. Here sext(C) copies bit 1 of C into bits 7..2.
- R6: Store writes reg[B] into dmem at the same address that a load would use.
- R7: Jump sets the next PC to PC + 1 + sext(C), modulo 256.
- R8: Add, load and store advance the PC by one, modulo 256.
- R9: After a cycle whose `reg_wr` is 1, `wb_reg` holds the written register number, `wb_val` holds its new value, and `wb_none` is 0. After a cycle with no register write, `wb_none` is 1 and `wb_reg`/`wb_val` keep their values.
- R10: After reset, dmem word i holds i for i < 16. Word 16 holds 0. Word i holds (16 - i) mod 256 for i > 16, so word 31 is 0xF1.
- R11: Store and jump leave all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| instr_in | input | 8 | Instruction at address `pc_out` |
| pc_out | output | 8 | Address of the instruction to execute |
| mem_rd | output | 1 | Current instruction reads the data store |
| mem_wr | output | 1 | Current instruction writes the data store |
| reg_wr | output | 1 | Current instruction writes a register |
| op_out | output | 2 | Opcode of the current instruction |
| wb_reg | output | 2 | Number of the register last written |
| wb_val | output | 8 | Value last written to a register |
| wb_none | output | 1 | Previous cycle wrote no register |

## Verification
The bench builds the core with its default parameters: 8-bit data, an 8-bit PC and a 32-word data store. In this configuration every one of the 256 instruction codes can be applied in several permuted orders. Between runs the bench resets the core, and it tracks registers, data store and PC in an arithmetic model. This configuration exercises the offset wrap from address 0 to word 31, the PC wrap on both jump and step, and the negative half of the reset pattern. Stores are confirmed by later loads that land on the same word.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;

   localparam int INSTR_W = 8;
   localparam int FIELD_W = 2;
   localparam int NUM_REGS = 1 << FIELD_W;

   typedef enum logic [FIELD_W-1:0] {
      OP_ADD   = 2'b00,
      OP_LOAD  = 2'b01,
      OP_STORE = 2'b10,
      OP_JUMP  = 2'b11
   } opcode_e;

   typedef struct packed {
      opcode_e              op;
      logic [FIELD_W-1:0]   fa;
      logic [FIELD_W-1:0]   fb;
      logic [FIELD_W-1:0]   fc;
   } instr_t;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic reg_wr;
      logic is_jump;
      logic is_add;
   } ctrl_t;

endpackage

// File: rtl/cpu4_decode.sv
module cpu4_decode
   import cpu4_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 8
) (
   input  instr_t             ins,
   output ctrl_t              ctl,
   output logic [DATA_W-1:0]  imm_data,
   output logic [PC_W-1:0]    imm_pc
);

   always_comb begin
      ctl         = '0;
      ctl.is_add  = (ins.op == OP_ADD);
      ctl.mem_rd  = (ins.op == OP_LOAD);
      ctl.mem_wr  = (ins.op == OP_STORE);
      ctl.is_jump = (ins.op == OP_JUMP);
      ctl.reg_wr  = ~ins.op[1];
   end

   // sign extension of the 2-bit offset field
   assign imm_data = {{(DATA_W-1){ins.fc[1]}}, ins.fc[0]};
   assign imm_pc   = {{(PC_W-1){ins.fc[1]}}, ins.fc[0]};

   always_comb begin
      if (!$isunknown(ins)) begin
         AST_STROBE_EXCL: assert (!(ctl.mem_rd && ctl.mem_wr) && !(ctl.mem_wr && ctl.reg_wr)); // R3
      end
   end

endmodule

// File: rtl/cpu4_regfile.sv
module cpu4_regfile
   import cpu4_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [FIELD_W-1:0]   rd_a_sel,
   input  logic [FIELD_W-1:0]   rd_b_sel,
   output logic [DATA_W-1:0]    rd_a,
   output logic [DATA_W-1:0]    rd_b,
   input  logic                 wr_en,
   input  logic [FIELD_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0]    wr_data
);

   logic [DATA_W-1:0] regs_q [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or posedge rst) begin
         if (rst)
            regs_q[r] <= '0;
         else if (wr_en && wr_sel == FIELD_W'(r))
            regs_q[r] <= wr_data;
      end
   end

   assign rd_a = regs_q[rd_a_sel];
   assign rd_b = regs_q[rd_b_sel];

   AST_RF_LAND: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data)); // R4

   AST_RF_KEEP: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (regs_q[0] == $past(regs_q[0])) && (regs_q[3] == $past(regs_q[3]))); // R11

endmodule

// File: rtl/cpu4_dmem.sv
module cpu4_dmem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [AW-1:0]      addr,
   output logic [DATA_W-1:0]  rdata,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wdata
);

   localparam int HALF = DEPTH / 2;

   // lower half counts up from 0, upper half counts down from 0
   function automatic logic [DATA_W-1:0] preset(input int idx);
      if (idx < HALF)
         return DATA_W'(idx);
      else
         return DATA_W'(HALF - idx);
   endfunction

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int w = 0; w < DEPTH; w++)
            mem_q[w] <= preset(w);
      end else if (wr_en) begin
         mem_q[addr] <= wdata;
      end
   end

   assign rdata = mem_q[addr];

   AST_ST_LAND: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> mem_q[$past(addr)] == $past(wdata)); // R6

endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
   import cpu4_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PC_W       = 8,
   parameter int DMEM_DEPTH = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [7:0]          instr_in,
   output logic [PC_W-1:0]     pc_out,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic                reg_wr,
   output logic [1:0]          op_out,
   output logic [1:0]          wb_reg,
   output logic [DATA_W-1:0]   wb_val,
   output logic                wb_none
);

   localparam int DM_AW = $clog2(DMEM_DEPTH);

   // elaboration-time parameter checks
   if (DATA_W < FIELD_W) begin : g_bad_data_w
      $error("cpu4_core: DATA_W must be at least %0d", FIELD_W);
   end
   if ((1 << DM_AW) != DMEM_DEPTH) begin : g_bad_depth
      $error("cpu4_core: DMEM_DEPTH must be a power of two");
   end
   if (DM_AW > DATA_W) begin : g_bad_reach
      $error("cpu4_core: data store larger than the address range");
   end
   if (PC_W < FIELD_W) begin : g_bad_pc_w
      $error("cpu4_core: PC_W too small");
   end

   instr_t            ins;
   ctrl_t             ctl;
   logic [DATA_W-1:0] imm_data;
   logic [PC_W-1:0]   imm_pc;
   logic [DATA_W-1:0] src_a, src_b, alu_rhs, alu_out;
   logic [DATA_W-1:0] dm_rdata, rf_wdata;
   logic [FIELD_W-1:0] rf_wsel;
   logic [PC_W-1:0]   pc_q, pc_next;

   assign ins = instr_t'(instr_in);

   cpu4_decode #(.DATA_W(DATA_W), .PC_W(PC_W)) u_dec (
      .ins      (ins),
      .ctl      (ctl),
      .imm_data (imm_data),
      .imm_pc   (imm_pc)
   );

   cpu4_regfile #(.DATA_W(DATA_W)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .rd_a_sel (ins.fa),
      .rd_b_sel (ins.fb),
      .rd_a     (src_a),
      .rd_b     (src_b),
      .wr_en    (ctl.reg_wr),
      .wr_sel   (rf_wsel),
      .wr_data  (rf_wdata)
   );

   // one adder serves both add and address generation
   assign alu_rhs = ctl.is_add ? src_b : imm_data;
   assign alu_out = src_a + alu_rhs;

   cpu4_dmem #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH)) u_dm (
      .clk   (clk),
      .rst   (rst),
      .addr  (alu_out[DM_AW-1:0]),
      .rdata (dm_rdata),
      .wr_en (ctl.mem_wr),
      .wdata (src_b)
   );

   assign rf_wsel  = ctl.is_add ? ins.fc : ins.fb;
   assign rf_wdata = ctl.is_add ? alu_out : dm_rdata;

   assign pc_next = pc_q + PC_W'(1) + (ctl.is_jump ? imm_pc : '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wb_reg  <= '0;
         wb_val  <= '0;
         wb_none <= 1'b1;
      end else if (ctl.reg_wr) begin
         wb_reg  <= rf_wsel;
         wb_val  <= rf_wdata;
         wb_none <= 1'b0;
      end else begin
         wb_none <= 1'b1;
      end
   end

   assign pc_out = pc_q;
   assign mem_rd = ctl.mem_rd;
   assign mem_wr = ctl.mem_wr;
   assign reg_wr = ctl.reg_wr;
   assign op_out = ins.op;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (instr_in[7:6] != 2'b11) |=> pc_out == $past(pc_out) + PC_W'(1)); // R8

   AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
      (instr_in[7:6] == 2'b11) |=>
         pc_out == $past(pc_out) + PC_W'(1) + {{(PC_W-1){$past(instr_in[1])}}, $past(instr_in[0])}); // R7

   AST_WB_SET: assert property (@(posedge clk) disable iff (rst)
      reg_wr |=> !wb_none); // R9

   AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
      !reg_wr |=> wb_none && (wb_val == $past(wb_val)) && (wb_reg == $past(wb_reg))); // R9

   AST_LOAD_DATA: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> (wb_val == $past(dm_rdata)) && (wb_reg == $past(instr_in[3:2]))); // R5

endmodule

// File: tb/cpu4_core_test.sv
module cpu4_core_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] instr_in = 8'h00;
   logic [7:0] pc_out;
   logic       mem_rd, mem_wr, reg_wr;
   logic [1:0] op_out, wb_reg;
   logic [7:0] wb_val;
   logic       wb_none;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_reg [4];
   logic [7:0] m_mem [32];
   logic [7:0] m_pc;
   logic [1:0] m_wbr;
   logic [7:0] m_wbv;
   logic       m_none;

   always #10 clk = ~clk;   // 50 MHz

   cpu4_core uut (
      .clk(clk), .rst(rst), .instr_in(instr_in), .pc_out(pc_out),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_wr(reg_wr), .op_out(op_out),
      .wb_reg(wb_reg), .wb_val(wb_val), .wb_none(wb_none)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h (time %0t)", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic [7:0] mk(input logic [1:0] op, input logic [1:0] a,
                                     input logic [1:0] b, input logic [1:0] c);
      return {op, a, b, c};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
      for (int i = 0; i < 32; i++) m_mem[i] = (i < 16) ? 8'(i) : 8'(16 - i);
      m_pc = 8'h00; m_wbr = 2'd0; m_wbv = 8'h00; m_none = 1'b1;
   endtask

   task automatic model_exec(input logic [7:0] ins);
      logic [1:0] a, b, c;
      logic [7:0] imm, ad;
      a = ins[5:4]; b = ins[3:2]; c = ins[1:0];
      imm = {{6{c[1]}}, c};
      ad = m_reg[a] + imm;
      m_none = 1'b1;
      case (ins[7:6])
         2'b00: begin m_reg[c] = m_reg[a] + m_reg[b]; m_wbr = c; m_wbv = m_reg[c]; m_none = 1'b0; end
         2'b01: begin m_reg[b] = m_mem[ad[4:0]]; m_wbr = b; m_wbv = m_reg[b]; m_none = 1'b0; end
         2'b10: m_mem[ad[4:0]] = m_reg[b];
         default: ;
      endcase
      m_pc = m_pc + 8'd1 + ((ins[7:6] == 2'b11) ? imm : 8'd0);
   endtask

   // apply one instruction, check strobes before the edge and state after it
   task automatic step(input logic [7:0] ins);
      string tag;
      instr_in = ins;
      #1;
      chk("R3 mem_wr", mem_wr, ins[7:6] == 2'b10);
      chk("R3 mem_rd", mem_rd, ins[7:6] == 2'b01);
      chk("R3 reg_wr", reg_wr, !ins[7]);
      chk("R3 op_out", op_out, ins[7:6]);
      @(posedge clk);
      model_exec(ins);
      @(negedge clk);
      chk((ins[7:6] == 2'b11) ? "R7 pc" : "R8 pc", pc_out, m_pc);
      chk("R9 wb_none", wb_none, m_none);
      case (ins[7:6])
         2'b00: tag = "R2 R4 add";
         2'b01: tag = "R5 load";
         default: tag = "R11 R9 hold";
      endcase
      chk(tag, wb_reg, m_wbr);
      chk(tag, wb_val, m_wbv);
   endtask

   task automatic do_reset();
      instr_in = 8'h00;
      rst = 1'b1;
      model_reset();
      #1;
      chk("R1 pc", pc_out, 0);
      chk("R1 wb_none", wb_none, 1);
      chk("R1 wb_reg", wb_reg, 0);
      chk("R1 wb_val", wb_val, 0);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin : main
      @(negedge clk);
      do_reset();

      // R1: registers start at zero
      step(mk(2'b00, 2'd1, 2'd2, 2'd3));
      chk("R1 regs zero", wb_val, 8'h00);

      // R10 and R5: offset -1 from 0 wraps to word 31, -2 to word 30
      step(mk(2'b01, 2'd0, 2'd1, 2'b11));
      chk("R10 word31", wb_val, 8'hF1);
      step(mk(2'b01, 2'd0, 2'd2, 2'b10));
      chk("R10 word30", wb_val, 8'hF2);

      // R7: backward jump from pc 3 by -2 lands on 2
      step(mk(2'b11, 2'd0, 2'd0, 2'b10));
      chk("R7 back jump", pc_out, 8'h02);

      // short program: load, jump, add, store, load
      do_reset();
      step(mk(2'b01, 2'd0, 2'd2, 2'd1));
      chk("R5 load word1", wb_val, 8'h01);
      step(mk(2'b11, 2'd0, 2'd0, 2'd1));
      chk("R7 jump +1", pc_out, 8'h03);
      step(mk(2'b00, 2'd1, 2'd2, 2'd0));
      chk("R4 add dest", wb_reg, 2'd0);
      step(mk(2'b10, 2'd2, 2'd2, 2'd1));
      chk("R6 store flag", wb_none, 1);
      step(mk(2'b01, 2'd1, 2'd3, 2'd1));
      chk("R5 load r3", wb_val, 8'h01);
      step(mk(2'b01, 2'd2, 2'd3, 2'd1));
      chk("R6 stored word2", wb_val, 8'h01);

      // R7: jump wrap below zero
      do_reset();
      step(mk(2'b11, 2'd0, 2'd0, 2'b10));
      chk("R7 wrap", pc_out, 8'hFF);
      step(mk(2'b00, 2'd0, 2'd0, 2'd0));
      chk("R8 wrap", pc_out, 8'h00);

      // sweeps: every code in several permuted orders
      for (int p = 0; p < 5; p++) begin
         if (p == 2) do_reset();
         for (int i = 0; i < 256; i++) begin
            int mul, off;
            mul = 1 + 2 * (p * 18 + 3 * p);
            off = 11 * p + 5;
            step(8'((i * mul + off) & 255));
         end
      end

      summary();
   end

endmodule